// File: doc/BRIEF.md
# Dual-Clock Parallel-Load Shift Register

This block is a nine-bit storage register with two modes. In load mode it captures a whole parallel word. In shift mode it moves its contents one place toward the top bit and takes a new serial bit in at the bottom. Every bit is driven out in parallel, and the top bit also acts as the serial output. Typical uses are scan-style diagnostic chains, turning a parallel word into a serial stream, and holding a byte together with its parity bit.

Two clock inputs are merged, so a rising edge on either one advances the register. The clock that is not in use must stay low. An active-high clear empties the register at once, without waiting for a clock edge. While the clear is high it overrides both modes.

Top module: `dual_clk_shift_reg`

## Requirements
- R1: After the clear has been applied, all WIDTH output bits (default 9) read 0.
- R2: With `mode` = 0 (load), each active edge copies `par_in[i]` into `q[i]` for every bit i.
- R3: With `mode` = 1 (shift), each active edge sets `q[i]` to the old `q[i-1]` for i from 1 to WIDTH-1, and sets `q[0]` to `ser_in`.
- R4: A rising edge on `clk_a` alone, with `clk_b` held low, performs one load or shift.
- R5: A rising edge on `clk_b` alone, with `clk_a` held low, performs one load or shift.
- R6: Raising `rst` clears all bits to 0 in the same time step, with no clock edge needed.
- R7: While `rst` is high, clock edges leave `q` at 0 in both modes.
- R8: `ser_out` always equals `q[WIDTH-1]`. After WIDTH shifts following a load, the loaded word has left through `ser_out`, highest bit first.
- R9: WIDTH must be at least 2. Smaller values stop elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | First clock; rising edge advances the register |
| clk_b | input | 1 | Second clock; rising edge advances the register |
| rst | input | 1 | Active-high asynchronous clear |
| mode | input | 1 | 0 = parallel load, 1 = shift toward the top bit |
| par_in | input | WIDTH | Parallel word captured in load mode |
| ser_in | input | 1 | Bit entering position 0 in shift mode |
| q | output | WIDTH | Register contents |
| ser_out | output | 1 | Serial output, the top bit of the register |

## Verification
The bench builds the block with its default WIDTH of 9. At that width a full byte plus a parity bit passes through the chain, so nine shifts empty a loaded word completely. With the top bit at index 8, an error in the bit-0 serial entry or in the top-bit tap shows up directly at `ser_out`. Loads and shifts are run from each clock separately. A clear is raised partway through a shift sequence, and further edges are applied while the clear is held, so both the immediate clear and the override of the clock can be observed against the reference model.

// File: rtl/sr_pkg.sv
package sr_pkg;
   typedef enum logic {
      SR_LOAD  = 1'b0,
      SR_SHIFT = 1'b1
   } sr_mode_e;

   localparam int SR_MIN_WIDTH = 2;
endpackage

// File: rtl/sr_clk_merge.sv
module sr_clk_merge #(
   parameter int NUM_CLK = 2
) (
   input  logic [NUM_CLK-1:0] clk_vec,
   output logic               clk_out
);
   // Any rising input gives a rising output while the other inputs stay low.
   assign clk_out = |clk_vec;
endmodule

// File: rtl/sr_stage.sv
module sr_stage (
   input  logic clk,
   input  logic rst,
   input  logic shift_en,
   input  logic par_bit,
   input  logic chain_bit,
   output logic q
);
   logic next_bit;

   always_comb begin
      next_bit = shift_en ? chain_bit : par_bit;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) q <= 1'b0;
      else     q <= next_bit;
   end
endmodule

// File: rtl/dual_clk_shift_reg.sv
module dual_clk_shift_reg
   import sr_pkg::*;
#(
   parameter int WIDTH = 9
) (
   input  logic             clk_a,
   input  logic             clk_b,
   input  logic             rst,
   input  logic             mode,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   output logic [WIDTH-1:0] q,
   output logic             ser_out
);
   localparam int TOP = WIDTH - 1;

   // R9: width check at elaboration
   generate
      if (WIDTH < SR_MIN_WIDTH) begin : g_bad_width
         $error("dual_clk_shift_reg: WIDTH must be at least %0d", SR_MIN_WIDTH);
      end
   endgenerate

   logic     clk_merged;
   sr_mode_e mode_e;
   logic     shift_en;

   assign mode_e   = sr_mode_e'(mode);
   assign shift_en = (mode_e == SR_SHIFT);

   sr_clk_merge #(.NUM_CLK(2)) u_merge (
      .clk_vec ({clk_b, clk_a}),
      .clk_out (clk_merged)
   );

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic chain_src;
         if (i == 0) begin : g_head
            assign chain_src = ser_in;
         end else begin : g_body
            assign chain_src = q[i-1];
         end
         sr_stage u_stage (
            .clk       (clk_merged),
            .rst       (rst),
            .shift_en  (shift_en),
            .par_bit   (par_in[i]),
            .chain_bit (chain_src),
            .q         (q[i])
         );
      end
   endgenerate

   assign ser_out = q[TOP];
endmodule

// File: rtl/sr_checker.sv
module sr_checker #(
   parameter int WIDTH = 9
) (
   input logic             clk_merged,
   input logic             clk_a,
   input logic             clk_b,
   input logic             rst,
   input logic             mode,
   input logic [WIDTH-1:0] par_in,
   input logic             ser_in,
   input logic [WIDTH-1:0] q,
   input logic             ser_out
);
   // R2
   load_word_chk: assert property (@(posedge clk_merged) disable iff (rst)
      !mode |=> q == $past(par_in));

   // R3
   shift_step_chk: assert property (@(posedge clk_merged) disable iff (rst)
      mode |=> q == {$past(q[WIDTH-2:0]), $past(ser_in)});

   // R7
   held_clear_chk: assert property (@(posedge clk_merged)
      rst |=> q == '0);

   // R4
   always_comb begin
      // R5
      single_clock_chk: assert ($onehot0({clk_a, clk_b}));
   end
endmodule

bind dual_clk_shift_reg sr_checker #(.WIDTH(WIDTH)) chk_i (
   .clk_merged (clk_merged),
   .clk_a      (clk_a),
   .clk_b      (clk_b),
   .rst        (rst),
   .mode       (mode),
   .par_in     (par_in),
   .ser_in     (ser_in),
   .q          (q),
   .ser_out    (ser_out)
);

// File: tb/dual_clk_shift_reg_tb_top.sv
module dual_clk_shift_reg_tb_top;
   localparam int W = 9;

   typedef struct {
      logic [W-1:0] exp_q;
      string        tag;
   } item_t;

   logic         clk_a = 0, clk_b = 0, rst = 0, mode = 0, ser_in = 0;
   logic [W-1:0] par_in = '0;
   logic [W-1:0] q;
   logic         ser_out;

   int checks = 0, errors = 0;
   item_t        sb[$];
   logic [W-1:0] model = '0;
   logic         done = 0;

   dual_clk_shift_reg #(.WIDTH(W)) dut_i (
      .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .mode(mode),
      .par_in(par_in), .ser_in(ser_in), .q(q), .ser_out(ser_out)
   );

   task automatic check_now(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // One 10 ns cycle (100 MHz) on the chosen clock; the expected value is queued first.
   task automatic step(bit use_b, bit m, logic [W-1:0] p, bit s, string tag);
      item_t it;
      mode = m; par_in = p; ser_in = s;
      if (rst)    model = '0;
      else if (m) model = {model[W-2:0], s};
      else        model = p;
      it.exp_q = model; it.tag = tag;
      sb.push_back(it);
      #5;
      if (use_b) clk_b = 1; else clk_a = 1;
      #5;
      clk_a = 0; clk_b = 0;
      #0;
   endtask

   // Monitor: compares at the falling edge, halfway between rising edges.
   initial begin
      forever begin
         @(negedge clk_a or negedge clk_b);
         if (sb.size() == 0) begin
            check_now("scoreboard-empty", '0, '1);
         end else begin
            item_t it;
            it = sb.pop_front();
            check_now(it.tag, q, it.exp_q);
            // R8: serial tap follows the top bit
            check_now("R8 ser_out", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, it.exp_q[W-1]});
         end
      end
   end

   initial begin
      #1ms;
      errors++; checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] word;
      logic [W-1:0] shifted_out;
      #1 rst = 1;
      #4;
      check_now("R1 reset state", q, '0);
      #5 rst = 0;
      model = '0;

      // R2 R4: load on clk_a, then R8: nine shifts stream the word out
      word = 9'h1A5;
      step(0, 0, word, 0, "R2 load clk_a");
      shifted_out = '0;
      for (int i = 0; i < W; i++) begin
         shifted_out = {shifted_out[W-2:0], ser_out};
         step(0, 1, '0, i[0], "R3 shift clk_a");
      end
      check_now("R8 serial stream", shifted_out, word);

      // R5: load and shift on clk_b only
      step(1, 0, 9'h0F3, 0, "R5 load clk_b");
      for (int i = 0; i < 4; i++) step(1, 1, '1, 1, "R5 shift clk_b");
      step(1, 0, 9'h100, 0, "R2 load top bit");
      step(1, 1, '0, 1, "R3 top bit leaves");

      // Alternate clocks across several patterns
      for (int k = 0; k < 6; k++) begin
         step(k[0], 0, 9'(k * 73 + 5), 0, "R2 load pattern");
         for (int i = 0; i < 3; i++) step(!k[0], 1, '0, ~i[0], "R3 shift pattern");
      end

      // R6: clear raised mid-shift, between edges
      step(0, 0, 9'h1FF, 0, "R2 load ones");
      step(0, 1, '0, 1, "R3 shift ones");
      #2 rst = 1;
      #1;
      check_now("R6 async clear", q, '0);
      model = '0;
      // R7: edges while the clear is held
      step(0, 0, 9'h155, 1, "R7 load blocked");
      step(1, 1, 9'h0AA, 1, "R7 shift blocked");
      rst = 0;
      step(1, 1, '0, 1, "R3 shift after clear");
      step(0, 0, 9'h0AA, 0, "R2 load after clear");

      #20;
      done = 1;
      check_now("scoreboard drained", W'(sb.size()), '0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule